// File: doc/BRIEF.md
# Buck Regulator Fault Supervisor

This block watches over a multi-phase buck converter. It takes a sampled core-voltage code, qualified by a valid strobe, and compares it with the programmed target code. From that comparison it derives three conditions. The first is an overvoltage condition, which latches. The second is an undervoltage condition, which does not latch and has hysteresis. The block also accepts an overcurrent flag from the current-sense logic. From these inputs it drives one power-good output and a two-bit mode for every PWM phase: normal, forced low or three-state.

After reset, the block runs a soft-start interval of a fixed number of clock cycles. During that interval all phases are normal and power-good stays low. The block then enters regulation.

An overcurrent sends all phases to three-state for one soft-start interval, after which the block restarts with a fresh soft-start. An overvoltage sets a latch that only a reset clears. While the latch is set, the block acts as a hysteretic shunt clamp. It drives all phases low while the voltage is above the limit. It releases them to three-state once the voltage drops below the limit minus a hysteresis band. It repeats this for as long as the cause persists.

Top module: `vreg_fault_sup`

## Requirements
- R1: While reset is held and during soft-start, power-good is low and all phases are normal (2'b00). Power-good rises exactly SS_CYCLES+2 clock edges after reset is released: two edges for the reset synchroniser, then SS_CYCLES edges of soft-start.
- R2: A sense code is taken only in a cycle where sense_valid is high. Overvoltage needs sense > target + floor(target*15/100); a code equal to that limit does not trigger it.
- R3: Once the overvoltage latch is set, power-good stays low and no phase returns to normal until reset. A new reset restarts soft-start and power-good comes back.
- R4: While the latch is set, a valid sample above the overvoltage limit drives every phase to forced low (2'b01) two edges after the sampling edge.
- R5: While the latch is set, a valid sample below (limit − floor(target*HYST_PCT/100)) drives every phase to three-state (2'b10). A sample inside the band keeps the current clamp mode.
- R6: While the latch is set, the clamp alternates between forced low and three-state as often as the voltage crosses the two thresholds.
- R7: A valid sample below target − floor(target*9/100) drops power-good without changing the phase modes. A sample equal to that limit leaves power-good high.
- R8: Undervoltage is not latched. Power-good returns when a valid sample reaches the undervoltage limit plus the hysteresis band, and stays low for samples between the limit and that level.
- R9: An overcurrent flag seen during regulation drives every phase to three-state and drops power-good on the next clock edge.
- R10: After an overcurrent, the phases stay three-state for SS_CYCLES edges. The block then runs a full soft-start with normal phases and power-good rises after another SS_CYCLES edges.
- R11: Overvoltage takes priority over overcurrent. An overcurrent flag is ignored while the latch is set, and the clamp mode is kept.
- R12: All phases always carry the same mode, and the unused code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset; release is synchronised inside |
| target_code | input | CODE_W | Programmed target voltage code |
| sense_code | input | CODE_W | Sampled core-voltage code |
| sense_valid | input | 1 | Qualifies sense_code for one cycle |
| oc_flag | input | 1 | Overcurrent indication |
| pwr_good | output | 1 | High when regulating with no fault present |
| phase_mode | output | 2*N_PHASE | Two-bit mode per phase: 00 normal, 01 forced low, 10 three-state |

## Verification
The sequencer state shows directly at the ports. A wrong state appears as a phase mode or power-good value that disagrees with the last sampled thresholds, two edges after the sample or one edge after an overcurrent. A clamp that is stuck or flips inside the hysteresis band shows up as the wrong mode on the next valid sample. A miscounted soft-start or wait interval moves the power-good rising edge by whole cycles, so the bench checks that edge to the exact cycle. A latch that clears on its own shows up as a normal mode or a high power-good while the latch should still be held.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_LOW    = 2'b01,
    PM_TRI    = 2'b10
  } phase_mode_e;

  typedef enum logic [1:0] {
    SQ_SOFT = 2'b00,
    SQ_RUN  = 2'b01,
    SQ_WAIT = 2'b10,
    SQ_OVL  = 2'b11
  } seq_state_e;
endpackage

// File: rtl/vfs_rst_sync.sv
module vfs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/vfs_window.sv
module vfs_window #(
  parameter int CODE_W   = 10,
  parameter int HYST_PCT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] target_code,
  input  logic [CODE_W-1:0] sense_code,
  input  logic              sense_valid,
  output logic              ov_above,
  output logic              ov_below_band,
  output logic              uv_flag
);
  localparam int XW = CODE_W + 8;

  logic [XW-1:0] tgt, sns, ov_lim, uv_lim, hyst;
  logic ov_above_q, ov_above_d;
  logic ov_band_q, ov_band_d;
  logic uv_q, uv_d;

  // thresholds from the target code
  always_comb begin
    tgt    = XW'(target_code);
    sns    = XW'(sense_code);
    ov_lim = tgt + (tgt * XW'(15)) / XW'(100);
    uv_lim = tgt - (tgt * XW'(9)) / XW'(100);
    hyst   = (tgt * XW'(HYST_PCT)) / XW'(100);
  end

  always_comb begin
    ov_above_d = ov_above_q;
    ov_band_d  = ov_band_q;
    uv_d       = uv_q;
    if (sense_valid) begin
      ov_above_d = (sns > ov_lim);
      ov_band_d  = (sns < (ov_lim - hyst));
      if (sns < uv_lim)
        uv_d = 1'b1;
      else if (sns >= (uv_lim + hyst))
        uv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_above_q <= 1'b0;
      ov_band_q  <= 1'b0;
      uv_q       <= 1'b0;
    end else begin
      ov_above_q <= ov_above_d;
      ov_band_q  <= ov_band_d;
      uv_q       <= uv_d;
    end
  end

  assign ov_above      = ov_above_q;
  assign ov_below_band = ov_band_q;
  assign uv_flag       = uv_q;
endmodule

// File: rtl/vfs_seq.sv
module vfs_seq
  import vfs_pkg::*;
#(
  parameter int SS_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ov_above,
  input  logic        ov_below_band,
  input  logic        uv_flag,
  input  logic        oc_flag,
  output phase_mode_e mode,
  output logic        pwr_good
);
  localparam int CW = $clog2(SS_CYCLES + 1);
  localparam logic [CW-1:0] SS_LAST = CW'(SS_CYCLES - 1);

  seq_state_e  state_q, state_d;
  phase_mode_e clamp_q, clamp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    state_d = state_q;
    clamp_d = clamp_q;
    cnt_d   = '0;
    cnt_en  = 1'b0;
    unique case (state_q)
      SQ_SOFT: begin
        if (ov_above) begin
          state_d = SQ_OVL;
          clamp_d = PM_LOW;
        end else if (oc_flag) begin
          state_d = SQ_WAIT;
        end else if (cnt_q == SS_LAST) begin
          state_d = SQ_RUN;
        end else begin
          cnt_d  = cnt_q + 1'b1;
        end
        cnt_en = 1'b1;
      end
      SQ_RUN: begin
        if (ov_above) begin
          state_d = SQ_OVL;
          clamp_d = PM_LOW;
        end else if (oc_flag) begin
          state_d = SQ_WAIT;
        end
        cnt_en = 1'b1;
      end
      SQ_WAIT: begin
        if (ov_above) begin
          state_d = SQ_OVL;
          clamp_d = PM_LOW;
        end else if (cnt_q == SS_LAST) begin
          state_d = SQ_SOFT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        cnt_en = 1'b1;
      end
      SQ_OVL: begin
        // latched: overcurrent ignored, hysteretic shunt clamp
        if (ov_above)
          clamp_d = PM_LOW;
        else if (ov_below_band)
          clamp_d = PM_TRI;
      end
      default: state_d = SQ_SOFT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_SOFT;
      clamp_q <= PM_LOW;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      clamp_q <= clamp_d;
      if (cnt_en)
        cnt_q <= cnt_d;
    end
  end

  always_comb begin
    unique case (state_q)
      SQ_WAIT: mode = PM_TRI;
      SQ_OVL:  mode = clamp_q;
      default: mode = PM_NORMAL;
    endcase
  end

  assign pwr_good = (state_q == SQ_RUN) && !uv_flag;
endmodule

// File: rtl/vfs_phase_drv.sv
module vfs_phase_drv
  import vfs_pkg::*;
#(
  parameter int N_PHASE = 4
) (
  input  phase_mode_e            mode,
  output logic [2*N_PHASE-1:0]   phase_mode
);
  for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
    assign phase_mode[2*p +: 2] = mode;
  end
endmodule

// File: rtl/vreg_fault_sup.sv
module vreg_fault_sup
  import vfs_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int N_PHASE   = 4,
  parameter int SS_CYCLES = 64,
  parameter int HYST_PCT  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CODE_W-1:0]    target_code,
  input  logic [CODE_W-1:0]    sense_code,
  input  logic                 sense_valid,
  input  logic                 oc_flag,
  output logic                 pwr_good,
  output logic [2*N_PHASE-1:0] phase_mode
);
  logic        rst_int_n;
  logic        ov_above, ov_below_band, uv_flag;
  phase_mode_e mode;

  vfs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  vfs_window #(.CODE_W(CODE_W), .HYST_PCT(HYST_PCT)) u_win (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .target_code   (target_code),
    .sense_code    (sense_code),
    .sense_valid   (sense_valid),
    .ov_above      (ov_above),
    .ov_below_band (ov_below_band),
    .uv_flag       (uv_flag)
  );

  vfs_seq #(.SS_CYCLES(SS_CYCLES)) u_seq (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .ov_above      (ov_above),
    .ov_below_band (ov_below_band),
    .uv_flag       (uv_flag),
    .oc_flag       (oc_flag),
    .mode          (mode),
    .pwr_good      (pwr_good)
  );

  vfs_phase_drv #(.N_PHASE(N_PHASE)) u_drv (
    .mode       (mode),
    .phase_mode (phase_mode)
  );
endmodule

// File: rtl/vreg_fault_sup_chk.sv
module vreg_fault_sup_chk #(
  parameter int N_PHASE = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 oc_flag,
  input logic                 pwr_good,
  input logic [2*N_PHASE-1:0] phase_mode
);
  p_phase_uniform_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_mode == {N_PHASE{phase_mode[1:0]}}) && (phase_mode[1:0] != 2'b11));

  p_pg_normal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> (phase_mode[1:0] == 2'b00));

  p_ov_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_mode[1:0] == 2'b01) |=> ((phase_mode[1:0] != 2'b00) && !pwr_good));

  p_oc_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && oc_flag) |=> (!pwr_good && (phase_mode[1:0] != 2'b00)));

  p_tri_no_pg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_mode[1:0] == 2'b10) |=> !pwr_good);
endmodule

bind vreg_fault_sup vreg_fault_sup_chk #(.N_PHASE(N_PHASE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .oc_flag    (oc_flag),
  .pwr_good   (pwr_good),
  .phase_mode (phase_mode)
);

// File: tb/vreg_fault_sup_test.sv
`timescale 1ns/1ps
module vreg_fault_sup_test;
  localparam int CODE_W = 10;
  localparam int NPH    = 4;
  localparam int SS     = 16;
  localparam logic [1:0] M_NORM = 2'b00, M_LOW = 2'b01, M_TRI = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CODE_W-1:0] target_code = 10'd500;
  logic [CODE_W-1:0] sense_code  = 10'd500;
  logic sense_valid = 1'b0;
  logic oc_flag = 1'b0;
  logic pwr_good;
  logic [2*NPH-1:0] phase_mode;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  vreg_fault_sup #(.CODE_W(CODE_W), .N_PHASE(NPH), .SS_CYCLES(SS), .HYST_PCT(2)) uut (
    .clk(clk), .rst_n(rst_n), .target_code(target_code), .sense_code(sense_code),
    .sense_valid(sense_valid), .oc_flag(oc_flag), .pwr_good(pwr_good), .phase_mode(phase_mode)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check_out(input logic [1:0] exp_mode, input logic exp_pg, input string tag);
    logic [2*NPH-1:0] exp_vec;
    exp_vec = {NPH{exp_mode}};
    checks++;
    if (phase_mode !== exp_vec || pwr_good !== exp_pg) begin
      failures++;
      $display("FAIL %s: actual mode=%b pg=%b expected mode=%b pg=%b",
               tag, phase_mode, pwr_good, exp_vec, exp_pg);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive a valid sample; return after the edge where the sequencer reacts.
  task automatic sample(input int code);
    @(negedge clk);
    sense_code  = CODE_W'(code);
    sense_valid = 1'b1;
    @(negedge clk);
    sense_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset_softstart(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    sense_code = 10'd500;
    oc_flag = 1'b0;
    wait_edges(3);
    check_out(M_NORM, 1'b0, {tag, " in reset"});
    rst_n = 1'b1;
    wait_edges(SS + 1);
    check_out(M_NORM, 1'b0, {tag, " soft-start last cycle"});
    wait_edges(1);
    check_out(M_NORM, 1'b1, {tag, " power-good after soft-start"});
  endtask

  task automatic t_undervoltage();
    sample(455);
    check_out(M_NORM, 1'b1, "R7 at uv limit");
    sample(454);
    check_out(M_NORM, 1'b0, "R7 below uv limit");
    sample(460);
    check_out(M_NORM, 1'b0, "R8 inside uv hysteresis");
    sample(465);
    check_out(M_NORM, 1'b1, "R8 uv released");
  endtask

  task automatic t_overcurrent();
    @(negedge clk);
    oc_flag = 1'b1;
    @(negedge clk);
    check_out(M_TRI, 1'b0, "R9 overcurrent tri-state");
    oc_flag = 1'b0;
    wait_edges(SS - 1);
    check_out(M_TRI, 1'b0, "R10 wait end");
    wait_edges(1);
    check_out(M_NORM, 1'b0, "R10 restart soft-start");
    wait_edges(SS - 1);
    check_out(M_NORM, 1'b0, "R10 soft-start last cycle");
    wait_edges(1);
    check_out(M_NORM, 1'b1, "R10 power-good back");
  endtask

  task automatic t_valid_gate();
    @(negedge clk);
    sense_code = 10'd600;
    wait_edges(4);
    check_out(M_NORM, 1'b1, "R2 sample without valid ignored");
    sample(575);
    check_out(M_NORM, 1'b1, "R2 at ov limit no trip");
  endtask

  task automatic t_overvoltage();
    sample(576);
    check_out(M_LOW, 1'b0, "R4 ov trip forced low");
    sample(570);
    check_out(M_LOW, 1'b0, "R5 band holds low");
    sample(564);
    check_out(M_TRI, 1'b0, "R5 below band tri-state");
    sample(570);
    check_out(M_TRI, 1'b0, "R5 band holds tri");
    sample(580);
    check_out(M_LOW, 1'b0, "R6 clamp again");
    sample(500);
    check_out(M_TRI, 1'b0, "R6 release again");
    sample(590);
    check_out(M_LOW, 1'b0, "R6 third clamp");
    @(negedge clk);
    oc_flag = 1'b1;
    wait_edges(3);
    check_out(M_LOW, 1'b0, "R11 overcurrent ignored in latch");
    oc_flag = 1'b0;
    sample(500);
    wait_edges(3 * SS);
    check_out(M_TRI, 1'b0, "R3 latch holds with normal voltage");
  endtask

  initial begin
    do_reset_softstart("R1");
    t_undervoltage();
    t_overcurrent();
    t_valid_gate();
    t_overvoltage();
    do_reset_softstart("R3 reset clears latch");
    t_overcurrent();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule